// File: doc/BRIEF.md
# Tone Transceiver Host Status Interface

This block sits between a host processor and the signalling core of a tone transceiver. The host reaches it over a strobed bus. The bus has an active-low chip select, separate active-low read and write strobes, one register-select line and a 4-bit data path. The data path is split into an input bus, an output bus and an output-enable. Through that bus the host loads the code to be sent, sets the operating mode, collects received codes and polls a 4-bit status word. Each status bit has its own rule for when it is set and when it is cleared.

On the core side, the block takes single-cycle event pulses from the tone detector and from the burst transmitter. A detector pulse carries either a validated code or news that the tone has gone away. A transmitter pulse reports that the inter-burst pause has run out. The block turns these events into status bits. It also drives an active-low interrupt request that the host can mask. The bus strobes are sampled on the system clock, so reads and writes take effect on the rising edge of the strobe. When a status event and a status read clear land in the same cycle, the event is kept.

Top module: `tonehost_if`

## Requirements
- R1: With select low, a read drives the receive code onto `dataOut` and a write loads the transmit register (`txData`). With select high, a read drives the status word onto `dataOut` and a write loads the control register. `dataOe` is high exactly while `csN` and `rdN` are both low.
- R2: A write takes effect on the rising edge of `wrN`, using the data present while the strobe was low. A transmit-register write produces one single-cycle `txLoad` pulse. A strobe given while `csN` is high changes nothing.
- R3: A `toneValid` pulse loads `toneCode` into the receive register and sets status bit 2 (receive full).
- R4: Status bit 1 (transmit ready) is set by `burstPauseDone` only while control bit 0 (burst enable) is 1. It is forced to 0 whenever burst enable is 0.
- R5: Status bit 3 (delayed steering) is set by `toneAbsent` and cleared by `toneValid`, and a status read leaves it unchanged. If both pulses arrive in the same cycle, the bit ends up clear.
- R6: The rising read edge of a status read clears status bits 0, 1 and 2. A set event in the same cycle keeps its bit set. A read of the receive register clears nothing.
- R7: Status bit 0 (interrupt) is set whenever bit 1 or bit 2 is set by an event. `irqN` is low exactly when control bit 1 (interrupt enable) is 1 and status bit 0 is 1.
- R8: After reset the status, control, receive and transmit registers are all 0, `irqN` is 1 and `txLoad` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| rs0 | input | 1 | Register select: 0 data, 1 status/control |
| dataIn | input | 4 | Host write data |
| dataOut | output | 4 | Host read data |
| dataOe | output | 1 | Read data enable for the external bus driver |
| irqN | output | 1 | Interrupt request, active low |
| toneValid | input | 1 | Detector pulse: valid tone with code |
| toneCode | input | 4 | Code that comes with `toneValid` |
| toneAbsent | input | 1 | Detector pulse: tone absence validated |
| burstPauseDone | input | 1 | Transmitter pulse: burst pause finished |
| txLoad | output | 1 | Pulse to the transmitter on a transmit-register write |
| txData | output | 4 | Transmit register contents |

## Verification
The collision that matters is a status read clearing the interrupt and receive-full bits in the same cycle that a new tone sets them. The bench raises the read strobe and then times a `toneValid` pulse to arrive on the exact edge where the clear is applied. It then reads the status again and expects bits 0 and 2 to still be set. A second collision, `toneAbsent` and `toneValid` arriving together, is driven with one pulse on both inputs, and the steering bit is expected to come out clear.

// File: rtl/tonehost_pkg.sv
package tonehost_pkg;

  // Strobes from the bus control to the register datapath
  typedef struct packed {
    logic wrTx;      // transmit register write
    logic wrCtrl;    // control register write
    logic rdStatus;  // status read completed (clear-on-read)
  } hostStrobe_t;

  // Status bit positions (host software decodes these)
  localparam int ST_IRQ = 0;
  localparam int ST_TXE = 1;
  localparam int ST_RXF = 2;
  localparam int ST_DST = 3;

  // Control bit positions
  localparam int CTL_BURST = 0;
  localparam int CTL_IRQEN = 1;

endpackage

// File: rtl/tonehost_ctrl.sv
module tonehost_ctrl
  import tonehost_pkg::*;
#(
  parameter int DATA_W     = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              rs0,
  input  logic [DATA_W-1:0] dataIn,
  output hostStrobe_t       strobes,
  output logic [DATA_W-1:0] wrData
);

  localparam int BUS_W = DATA_W + 4;
  localparam logic [BUS_W-1:0] BUS_IDLE = {3'b111, 1'b0, {DATA_W{1'b0}}};

  logic [BUS_W-1:0] busNow;
  logic [BUS_W-1:0] busPipe [SYNC_DEPTH];

  assign busNow = {csN, rdN, wrN, rs0, dataIn};

  // Sampling pipeline: stage SYNC_DEPTH-2 is "current", last is "previous"
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_DEPTH; gi++) begin : g_pipe
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) busPipe[gi] <= BUS_IDLE;
        else if (gi == 0) busPipe[gi] <= busNow;
        else busPipe[gi] <= busPipe[gi-1];
      end
    end
  endgenerate

  logic              csQ, rdQ, wrQ;
  logic              csPrev, rdPrev, wrPrev, rs0Prev;
  logic [DATA_W-1:0] dataPrev;
  logic              rs0Unused;
  logic [DATA_W-1:0] dataUnused;

  assign {csQ, rdQ, wrQ, rs0Unused, dataUnused} = busPipe[SYNC_DEPTH-2];
  assign {csPrev, rdPrev, wrPrev, rs0Prev, dataPrev} = busPipe[SYNC_DEPTH-1];

  logic wrRise, rdRise;

  always_comb begin
    wrRise = wrQ && !wrPrev && !csPrev;
    rdRise = rdQ && !rdPrev && !csPrev;
    strobes.wrTx     = wrRise && !rs0Prev;
    strobes.wrCtrl   = wrRise && rs0Prev;
    strobes.rdStatus = rdRise && rs0Prev;
    wrData = dataPrev;
  end

  logic csUnused;
  assign csUnused = csQ;

endmodule

// File: rtl/tonehost_dp.sv
module tonehost_dp
  import tonehost_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  hostStrobe_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic              csN,
  input  logic              rdN,
  input  logic              rs0,
  input  logic              toneValid,
  input  logic [DATA_W-1:0] toneCode,
  input  logic              toneAbsent,
  input  logic              burstPauseDone,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic [3:0]        status,
  output logic              burstEn,
  output logic              irqEn,
  output logic [DATA_W-1:0] txData,
  output logic              txLoad,
  output logic              irqN
);

  logic [DATA_W-1:0] ctrlReg, ctrlNxt;
  logic [DATA_W-1:0] rxReg;
  logic [3:0]        statusNxt;
  logic              burstNxt, rxSet, txSet, rdClr;

  always_comb begin
    ctrlNxt  = strobes.wrCtrl ? wrData : ctrlReg;
    burstNxt = ctrlNxt[CTL_BURST];
    rxSet    = toneValid;
    txSet    = burstPauseDone && burstNxt;
    rdClr    = strobes.rdStatus;

    statusNxt[ST_RXF] = rxSet || (status[ST_RXF] && !rdClr);
    statusNxt[ST_TXE] = burstNxt && (txSet || (status[ST_TXE] && !rdClr));
    statusNxt[ST_IRQ] = rxSet || txSet || (status[ST_IRQ] && !rdClr);
    if (toneValid)       statusNxt[ST_DST] = 1'b0;
    else if (toneAbsent) statusNxt[ST_DST] = 1'b1;
    else                 statusNxt[ST_DST] = status[ST_DST];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      rxReg   <= '0;
      txData  <= '0;
      txLoad  <= 1'b0;
      status  <= '0;
    end else begin
      ctrlReg <= ctrlNxt;
      status  <= statusNxt;
      txLoad  <= strobes.wrTx;
      if (strobes.wrTx) txData <= wrData;
      if (toneValid)    rxReg  <= toneCode;
    end
  end

  assign burstEn = ctrlReg[CTL_BURST];
  assign irqEn   = ctrlReg[CTL_IRQEN];

  always_comb begin
    dataOe  = !csN && !rdN;
    dataOut = rs0 ? DATA_W'(status) : rxReg;
    irqN    = !(irqEn && status[ST_IRQ]);
  end

endmodule

// File: rtl/tonehost_if.sv
module tonehost_if
  import tonehost_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              rs0,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              irqN,
  input  logic              toneValid,
  input  logic [DATA_W-1:0] toneCode,
  input  logic              toneAbsent,
  input  logic              burstPauseDone,
  output logic              txLoad,
  output logic [DATA_W-1:0] txData
);

  hostStrobe_t       strobesW;
  logic [DATA_W-1:0] wrDataW;
  logic [3:0]        statusW;
  logic              burstEnW, irqEnW;

  tonehost_ctrl #(.DATA_W(DATA_W), .SYNC_DEPTH(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN), .rs0(rs0),
    .dataIn(dataIn), .strobes(strobesW), .wrData(wrDataW)
  );

  tonehost_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobesW), .wrData(wrDataW),
    .csN(csN), .rdN(rdN), .rs0(rs0),
    .toneValid(toneValid), .toneCode(toneCode), .toneAbsent(toneAbsent),
    .burstPauseDone(burstPauseDone),
    .dataOut(dataOut), .dataOe(dataOe), .status(statusW),
    .burstEn(burstEnW), .irqEn(irqEnW),
    .txData(txData), .txLoad(txLoad), .irqN(irqN)
  );

endmodule

// File: rtl/tonehost_chk.sv
module tonehost_chk (
  input logic       clk,
  input logic       rstN,
  input logic       toneValid,
  input logic       toneAbsent,
  input logic       burstPauseDone,
  input logic       rdStatus,
  input logic [3:0] status,
  input logic       burstEn,
  input logic       txLoad
);

  p_rx_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    toneValid |=> status[2]);

  p_tx_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !burstEn |-> !status[1]);

  p_steer_clr_r5: assert property (@(posedge clk) disable iff (!rstN)
    toneValid |=> !status[3]);

  p_steer_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    (toneAbsent && !toneValid) |=> status[3]);

  p_read_clr_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdStatus && !toneValid && !burstPauseDone) |=> (!status[0] && !status[2]));

  p_irq_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    (toneValid || (burstPauseDone && burstEn)) |=> status[0]);

  p_load_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    txLoad |=> !txLoad);

endmodule

bind tonehost_if tonehost_chk u_chk (
  .clk(clk), .rstN(rstN), .toneValid(toneValid), .toneAbsent(toneAbsent),
  .burstPauseDone(burstPauseDone), .rdStatus(strobesW.rdStatus),
  .status(statusW), .burstEn(burstEnW), .txLoad(txLoad)
);

// File: tb/tonehost_if_bench.sv
`timescale 1ns/100ps
module tonehost_if_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1, rdN = 1'b1, wrN = 1'b1, rs0 = 1'b0;
  logic [3:0] dataIn = '0;
  logic [3:0] dataOut;
  logic       dataOe, irqN, txLoad;
  logic       toneValid = 1'b0, toneAbsent = 1'b0, burstPauseDone = 1'b0;
  logic [3:0] toneCode = '0;
  logic [3:0] txData;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tonehost_if u_tonehost_if (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN), .rs0(rs0),
    .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe), .irqN(irqN),
    .toneValid(toneValid), .toneCode(toneCode), .toneAbsent(toneAbsent),
    .burstPauseDone(burstPauseDone), .txLoad(txLoad), .txData(txData)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Full read cycle; the clear (if any) has been applied when this returns
  task automatic busRead(input logic sel, output logic [3:0] val);
    @(negedge clk);
    csN = 1'b0; rs0 = sel; rdN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    val = dataOut;
    chk("R1 dataOe during read", {3'b0, dataOe}, 4'b0001);
    rdN = 1'b1; csN = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk("R1 dataOe idle", {3'b0, dataOe}, 4'b0000);
  endtask

  // Full write cycle; returns at the negedge where txLoad would be high
  task automatic busWrite(input logic sel, input logic [3:0] d, input logic selChip);
    @(negedge clk);
    csN = !selChip; rs0 = sel; dataIn = d; wrN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    wrN = 1'b1; csN = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(input logic v, input logic a, input logic b, input logic [3:0] code);
    @(negedge clk);
    toneValid = v; toneAbsent = a; burstPauseDone = b; toneCode = code;
    @(negedge clk);
    toneValid = 1'b0; toneAbsent = 1'b0; burstPauseDone = 1'b0;
  endtask

  task automatic t_reset();
    logic [3:0] v;
    chk("R8 irqN after reset", {3'b0, irqN}, 4'b0001);
    chk("R8 txLoad after reset", {3'b0, txLoad}, 4'b0000);
    chk("R8 txData after reset", txData, 4'h0);
    busRead(1'b1, v); chk("R8 status after reset", v, 4'b0000);
    busRead(1'b0, v); chk("R8 rx after reset", v, 4'h0);
  endtask

  task automatic t_receive();
    logic [3:0] v;
    pulse(1'b1, 1'b0, 1'b0, 4'h9);
    busRead(1'b0, v); chk("R3 rx code", v, 4'h9);
    busRead(1'b1, v); chk("R6 rx read keeps status / R3 R7 set", v, 4'b0101);
    busRead(1'b1, v); chk("R6 status cleared by read", v, 4'b0000);
  endtask

  task automatic t_steer();
    logic [3:0] v;
    pulse(1'b0, 1'b1, 1'b0, 4'h0);
    busRead(1'b1, v); chk("R5 steer set", v, 4'b1000);
    busRead(1'b1, v); chk("R5 steer not cleared by read", v, 4'b1000);
    pulse(1'b1, 1'b0, 1'b0, 4'h3);
    busRead(1'b1, v); chk("R5 steer cleared by tone", v, 4'b0101);
    busRead(1'b0, v); chk("R3 second code", v, 4'h3);
    pulse(1'b1, 1'b1, 1'b0, 4'h6);
    busRead(1'b1, v); chk("R5 simultaneous absent+valid", v, 4'b0101);
    busRead(1'b1, v); chk("R6 cleared", v, 4'b0000);
  endtask

  task automatic t_write();
    busWrite(1'b0, 4'hA, 1'b1);
    chk("R2 txLoad pulse", {3'b0, txLoad}, 4'b0001);
    chk("R1 txData loaded", txData, 4'hA);
    @(negedge clk);
    chk("R2 txLoad single cycle", {3'b0, txLoad}, 4'b0000);
    busWrite(1'b0, 4'h5, 1'b0);
    chk("R2 deselected write no pulse", {3'b0, txLoad}, 4'b0000);
    chk("R2 deselected write ignored", txData, 4'hA);
  endtask

  task automatic t_burst();
    logic [3:0] v;
    pulse(1'b0, 1'b0, 1'b1, 4'h0);
    busRead(1'b1, v); chk("R4 pause ignored in non-burst", v, 4'b0000);
    busWrite(1'b1, 4'b0001, 1'b1);
    pulse(1'b0, 1'b0, 1'b1, 4'h0);
    @(negedge clk);
    chk("R7 irqN masked", {3'b0, irqN}, 4'b0001);
    busRead(1'b1, v); chk("R4 R7 tx ready set", v, 4'b0011);
    busWrite(1'b1, 4'b0011, 1'b1);
    pulse(1'b0, 1'b0, 1'b1, 4'h0);
    @(negedge clk);
    chk("R7 irqN asserted", {3'b0, irqN}, 4'b0000);
    busWrite(1'b1, 4'b0010, 1'b1);
    chk("R7 irqN held after mode change", {3'b0, irqN}, 4'b0000);
    busRead(1'b1, v); chk("R4 tx ready cleared by non-burst", v, 4'b0001);
    chk("R7 irqN released after read", {3'b0, irqN}, 4'b0001);
  endtask

  task automatic t_collide();
    logic [3:0] v;
    @(negedge clk);
    csN = 1'b0; rs0 = 1'b1; rdN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rdN = 1'b1; csN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    toneValid = 1'b1; toneCode = 4'hC;
    @(posedge clk);
    @(negedge clk);
    toneValid = 1'b0;
    busRead(1'b1, v); chk("R6 set wins over read clear", v, 4'b0101);
    busRead(1'b0, v); chk("R3 collided code", v, 4'hC);
    busRead(1'b1, v); chk("R6 cleared after collision", v, 4'b0000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_receive();
    t_steer();
    t_write();
    t_burst();
    t_collide();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule